// File: doc/BRIEF.md
# Audio Master Clock and Frame Timing Generator

This block turns a fast generic clock into the timing that an audio serializer needs when it drives the bus as master. It runs a master-clock divider and a frame timer from the same input clock. The block drives no derived clocks. Each output is a one-cycle enable strobe or a level in the generic clock domain. Downstream logic can use these directly or turn them into pin waveforms.

The master-clock strobe fires once every `M+1` input cycles, where `M` is the 6-bit master divider field. A mode input chooses whether the strobe is produced at all. The 6-bit frame field `F` sets the frame length to `32*(F+1)` input cycles. Each frame carries two 32-bit slots, so there are 64 bit strobes per frame. Word select is low for the first slot and high for the second.

Software programs both fields while the block is stopped and then issues a start command. A stop command does not cut the current frame short. The frame runs to its last cycle and then every output falls low together, so no shortened frame or partial word-select pulse reaches the serializer.

Top module: `audio_clkgen`

## Requirements
- R1: After reset the block is idle and `running`, `mck_stb`, `bclk_stb`, `ws` and `frame_stb` are all 0.
- R2: A `start_cmd` sampled while idle makes `running` 1 in the next cycle, and `frame_stb` is 1 in that same cycle. A `start_cmd` sampled while running has no effect on frame timing.
- R3: While running, `frame_stb` pulses once every `32*(fs_div_cfg+1)` cycles.
- R4: Within each frame, `ws` is 0 for the first `16*(fs_div_cfg+1)` cycles and 1 for the remaining `16*(fs_div_cfg+1)` cycles.
- R5: With `fs_div_cfg` of 1 or more, exactly 64 `bclk_stb` pulses occur per frame. They are spaced by a fractional-step phase accumulator. With `fs_div_cfg` of 0, `bclk_stb` is 1 on every cycle, which gives 32 per frame.
- R6: With `mck_en_cfg` = 1, `mck_stb` pulses once every `mck_div_cfg+1` cycles, counted from the first running cycle. A value of 0 gives a pulse on every cycle. With `mck_en_cfg` = 0, `mck_stb` stays 0.
- R7: A `stop_cmd` sampled while running lets the current frame finish. `running` falls in the cycle after the frame's last cycle, and from then on all outputs are 0.
- R8: The divider fields and the mode bit are captured on the start command. Changes to these inputs while running have no effect until the next start.
- R9: A `stop_cmd` sampled while idle has no effect: `running` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generic input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_cmd | input | 1 | Clock-enable command, one-cycle pulse |
| stop_cmd | input | 1 | Clock-disable command, one-cycle pulse |
| mck_div_cfg | input | 6 | Master divider field M: strobe every M+1 cycles |
| fs_div_cfg | input | 6 | Frame field F: frame is 32*(F+1) cycles |
| mck_en_cfg | input | 1 | 1: produce master-clock strobe, 0: suppress it |
| running | output | 1 | Generator active |
| mck_stb | output | 1 | Master clock enable strobe |
| bclk_stb | output | 1 | Bit clock enable strobe |
| ws | output | 1 | Word select level |
| frame_stb | output | 1 | First cycle of each frame |

## Verification
The bench uses the default parameters: 6-bit fields, a 32-tick frame and a step of two bits per tick. With these values the full field range is reachable, including the 2048-cycle frame at field value 63. It also exercises the saturated bit-strobe case at field value 0 and an odd frame divisor (field value 4), where bit spacing alternates between 2 and 3 cycles. Master divider values are chosen to divide the frame length, so each frame holds an exact, predictable number of master strobes.

// File: rtl/acg_pkg.sv
// Shared types for the audio clock generator.
// Assumes: single clock domain, synchronous active-low reset.
package acg_pkg;
    typedef enum logic [0:0] {
        ACG_IDLE = 1'b0,
        ACG_RUN  = 1'b1
    } acg_state_e;
endpackage

// File: rtl/acg_mck_div.sv
// Master-clock divider: one-cycle strobe every (div+1) cycles while run is high.
// Assumes: div is held stable while run is high; the counter rests at 0 when idle.
module acg_mck_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             stb
);
    logic [DIV_W-1:0] cnt_q;

    // Terminal-count strobe
    always_comb stb = run && (cnt_q == div);

    // Count up while running, reload on terminal count, rest at zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run)     cnt_q <= '0;
        else if (cnt_q == div)  cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // R6
    mck_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div));
endmodule

// File: rtl/acg_frame_timer.sv
// Frame timer: a (div+1)-cycle prescaler drives a 2**SLOT_W tick counter.
// The top tick bit is the word select; the frame starts at tick 0, prescale 0.
// Assumes: div is held stable while run is high.
module acg_frame_timer #(
    parameter int DIV_W  = 6,
    parameter int SLOT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             first,
    output logic             last,
    output logic             ws
);
    logic [DIV_W-1:0]  sub_q;
    logic [SLOT_W-1:0] tick_q;

    // Frame position decode, gated by run
    always_comb begin
        first = run && (sub_q == '0)  && (tick_q == '0);
        last  = run && (sub_q == div) && (tick_q == '1);
        ws    = run && tick_q[SLOT_W-1];
    end

    // Prescaler and tick counter, both wrap, cleared while idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sub_q  <= '0;
            tick_q <= '0;
        end else if (sub_q == div) begin
            sub_q  <= '0;
            tick_q <= tick_q + 1'b1;
        end else begin
            sub_q  <= sub_q + 1'b1;
        end
    end

    // R3
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (sub_q != div)) |=> (tick_q == $past(tick_q)));
    // R3
    sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (sub_q <= div));
endmodule

// File: rtl/acg_bit_phase.sv
// Bit-strobe generator: a phase accumulator adds STEP each cycle and wraps at (div+1).
// Each wrap is one bit strobe, which gives STEP strobes per (div+1) cycles.
// Assumes: div is stable while run is high. If div+1 < STEP, it saturates to one strobe per cycle.
module acg_bit_phase #(
    parameter int DIV_W = 6,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             stb
);
    localparam int ACC_W = DIV_W + 2;

    logic [ACC_W-1:0] acc_q, sum, modulus, acc_d;
    logic             sat, hit;

    // Next phase and wrap detection
    always_comb begin
        modulus = ACC_W'(div) + ACC_W'(1);
        sum     = acc_q + ACC_W'(STEP);
        sat     = modulus < ACC_W'(STEP);
        hit     = sat || (sum >= modulus);
        acc_d   = sat ? '0 : (hit ? sum - modulus : sum);
        stb     = run && hit;
    end

    // Phase register, cleared while idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) acc_q <= '0;
        else                acc_q <= acc_d;
    end

    // R5
    acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (acc_q < modulus));
endmodule

// File: rtl/audio_clkgen.sv
// Audio master clock and frame timing generator, top level.
// Captures the divider fields on start, runs three timing units, and stops only on a frame boundary.
// Assumes: start/stop are single-cycle commands in the clk domain.
module audio_clkgen #(
    parameter int DIV_W    = 6,
    parameter int SLOT_W   = 5,
    parameter int BIT_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic [DIV_W-1:0] mck_div_cfg,
    input  logic [DIV_W-1:0] fs_div_cfg,
    input  logic             mck_en_cfg,
    output logic             running,
    output logic             mck_stb,
    output logic             bclk_stb,
    output logic             ws,
    output logic             frame_stb
);
    import acg_pkg::*;

    acg_state_e       state_q;
    logic             stop_pend_q;
    logic [DIV_W-1:0] mck_div_q, fs_div_q;
    logic             mck_en_q;
    logic             frame_last;
    logic             mck_raw;

    always_comb running = (state_q == ACG_RUN);

    // Run control: start while idle, stop deferred to the last cycle of a frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ACG_IDLE;
            stop_pend_q <= 1'b0;
            mck_div_q   <= '0;
            fs_div_q    <= '0;
            mck_en_q    <= 1'b0;
        end else if (state_q == ACG_IDLE) begin
            stop_pend_q <= 1'b0;
            if (start_cmd) begin
                state_q   <= ACG_RUN;
                mck_div_q <= mck_div_cfg;
                fs_div_q  <= fs_div_cfg;
                mck_en_q  <= mck_en_cfg;
            end
        end else if (frame_last && (stop_pend_q || stop_cmd)) begin
            state_q     <= ACG_IDLE;
            stop_pend_q <= 1'b0;
        end else if (stop_cmd) begin
            stop_pend_q <= 1'b1;
        end
    end

    acg_mck_div #(.DIV_W(DIV_W)) u_mck (
        .clk(clk), .rst_n(rst_n), .run(running), .div(mck_div_q), .stb(mck_raw)
    );

    acg_frame_timer #(.DIV_W(DIV_W), .SLOT_W(SLOT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .run(running), .div(fs_div_q),
        .first(frame_stb), .last(frame_last), .ws(ws)
    );

    acg_bit_phase #(.DIV_W(DIV_W), .STEP(BIT_STEP)) u_bit (
        .clk(clk), .rst_n(rst_n), .run(running), .div(fs_div_q), .stb(bclk_stb)
    );

    // Mode gate on the master strobe
    always_comb mck_stb = mck_raw && mck_en_q;

    // R2
    start_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd && !running) |=> (running && frame_stb));
    // R7
    stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && frame_last && (stop_cmd || stop_pend_q)) |=> !running);
    // R7
    no_early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !frame_last) |=> running);
    // R9
    idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_cmd) |=> !running);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !(mck_stb || bclk_stb || ws || frame_stb));
endmodule

// File: tb/audio_clkgen_tb.sv
// Scoreboard bench: the driver queues one expected record per frame, and the monitor
// measures each completed frame and compares it with the head of the queue.
module audio_clkgen_tb_top;
    typedef struct {
        int per;
        int bits;
        int wshi;
        int mck;
    } frame_rec_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_cmd = 1'b0, stop_cmd = 1'b0;
    logic [5:0] mck_div_cfg = '0, fs_div_cfg = '0;
    logic       mck_en_cfg = 1'b0;
    logic       running, mck_stb, bclk_stb, ws, frame_stb;

    int checks = 0, errors = 0;
    frame_rec_t exp_q[$];
    int m_cnt = 0, m_bits = 0, m_wshi = 0, m_mck = 0;

    always #10 clk = ~clk;

    audio_clkgen dut_i (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .mck_div_cfg(mck_div_cfg), .fs_div_cfg(fs_div_cfg), .mck_en_cfg(mck_en_cfg),
        .running(running), .mck_stb(mck_stb), .bclk_stb(bclk_stb), .ws(ws),
        .frame_stb(frame_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare_frame();
        frame_rec_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected extra frame", m_cnt, 0);
        end else begin
            e = exp_q.pop_front();
            chk(m_cnt  == e.per,  "R3 frame length",     m_cnt,  e.per);
            chk(m_bits == e.bits, "R5 bit strobes",      m_bits, e.bits);
            chk(m_wshi == e.wshi, "R4 ws high cycles",   m_wshi, e.wshi);
            chk(m_mck  == e.mck,  "R6 master strobes",   m_mck,  e.mck);
        end
    endtask

    // Monitor: accumulate per-frame measurements away from the active edge
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (frame_stb) begin
                if (m_cnt > 0) compare_frame();
                m_cnt = 1; m_bits = int'(bclk_stb); m_wshi = int'(ws); m_mck = int'(mck_stb);
            end else begin
                m_cnt++; m_bits += int'(bclk_stb); m_wshi += int'(ws); m_mck += int'(mck_stb);
            end
        end else if (m_cnt > 0) begin
            compare_frame();
            m_cnt = 0;
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start_cmd = 1'b1;
        @(posedge clk); #1 start_cmd = 1'b0;
    endtask

    task automatic pulse_stop();
        @(posedge clk); #1 stop_cmd = 1'b1;
        @(posedge clk); #1 stop_cmd = 1'b0;
    endtask

    // Driver: configure, start, queue k expected frames, stop inside frame k
    task automatic run_case(input int m, input int f, input bit en, input int k, input bit tamper);
        int per;
        frame_rec_t r;
        per = 32 * (f + 1);
        mck_div_cfg = 6'(m); fs_div_cfg = 6'(f); mck_en_cfg = en;
        r.per = per; r.bits = (f == 0) ? 32 : 64; r.wshi = 16 * (f + 1);
        r.mck = en ? per / (m + 1) : 0;
        for (int i = 0; i < k; i++) exp_q.push_back(r);
        pulse_start();
        #2 chk(running == 1'b1 && frame_stb == 1'b1, "R2 start begins frame", int'(running), 1);
        if (tamper) begin
            // R8: field changes while running; R2: start while running ignored
            mck_div_cfg = 6'(m + 5); fs_div_cfg = 6'(f + 3); mck_en_cfg = ~en;
            pulse_start();
        end
        repeat ((k - 1) * per + per / 2) @(posedge clk);
        pulse_stop();
        while (running) @(posedge clk);
        repeat (3) @(posedge clk);
        #2;
        chk(exp_q.size() == 0, "R7 all queued frames completed", exp_q.size(), 0);
        chk({running, mck_stb, bclk_stb, ws, frame_stb} == 5'b0, "R7 outputs low after stop",
            int'({running, mck_stb, bclk_stb, ws, frame_stb}), 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1
        chk({running, mck_stb, bclk_stb, ws, frame_stb} == 5'b0, "R1 reset state",
            int'({running, mck_stb, bclk_stb, ws, frame_stb}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(posedge clk); #2;
        chk(running == 1'b0, "R1 idle after reset", int'(running), 0);

        // R9: stop while idle has no effect
        pulse_stop();
        repeat (2) @(posedge clk); #2;
        chk(running == 1'b0 && frame_stb == 1'b0, "R9 idle stop ignored", int'(running), 0);

        run_case(0, 1, 1'b1, 3, 1'b0);   // R5 one bit per cycle, R6 M=0
        run_case(7, 63, 1'b1, 2, 1'b1);  // R3 longest frame, R8 tamper
        run_case(2, 4, 1'b0, 3, 1'b0);   // R5 fractional spacing, R6 suppressed
        run_case(1, 0, 1'b1, 2, 1'b1);   // R5 saturated, R2 restart ignored
        run_case(3, 15, 1'b1, 1, 1'b0);  // R7 stop in the first frame

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule